// File: doc/BRIEF.md
# Per-CPU Timer and Interprocessor Interrupt Register

This block is one control register inside a chipset interrupt unit. It keeps two kinds of per-processor interrupt state. The first is a periodic timer interrupt. Each tick from an external divider posts it to every populated processor that has not yet taken the previous one. The second is an interprocessor interrupt. Software requests it by writing the register and acknowledges it by writing the register again.

The register is written with a 64-bit data word and a strobe. Each write may at once acknowledge timer interrupts, request interprocessor interrupts and acknowledge interprocessor interrupts. Interprocessor requests are counted per processor. The level-3 line therefore stays up until every outstanding request has been acknowledged. A static count input gives the number of populated processors. Every action is confined to those processors.

Top module: `cpu_tick_ipi_reg`

## Requirements
- R1: After reset all status bits, pending counts and both interrupt outputs are zero, and rd_data reads zero.
- R2: On a tick, every present CPU i whose timer status is clear gets rd_data bit 4+i set and irq_timer[i] raised, visible the cycle after the tick.
- R3: A tick leaves an already pending timer interrupt unchanged.
- R4: A write with bit 4+i set clears a pending timer status and lowers irq_timer[i]. On a CPU with no pending timer it has no effect. When a tick coincides with the acknowledge of a pending CPU, the acknowledge wins.
- R5: A write with bit 12+i set sets status bit 8+i, adds one to CPU i's pending count and raises irq_ipi[i].
- R6: A write with bit 8+i set clears status bit 8+i and subtracts one from the pending count. irq_ipi[i] stays high while the count is non-zero and drops when it reaches zero.
- R7: The pending count saturates at 2^CNT_W-1. An acknowledge on a zero count changes nothing.
- R8: When a single write both requests and acknowledges the same CPU, the request is applied first and the acknowledge second.
- R9: CPUs with index at or above cpu_count ignore ticks, requests and acknowledges.
- R10: Write bits outside 4..15 are ignored. rd_data bits 0..3 and 12..63 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| cpu_count | input | $clog2(NCPU+1) | Number of populated CPUs |
| rd_data | output | 64 | Current register contents |
| irq_timer | output | NCPU | Level-2 timer interrupt per CPU |
| irq_ipi | output | NCPU | Level-3 interprocessor interrupt per CPU |

## Verification
A wrong timer status appears on rd_data and irq_timer in the first cycle after the write or tick that caused it. A wrong pending count stays hidden while irq_ipi is high. It shows only when the run of acknowledges ends, where irq_ipi drops early or late. The bench therefore drives long request and acknowledge runs up to saturation, so that a counting fault reaches the port at the boundary.

// File: rtl/cpu_tick_ipi_reg.sv
module cpu_tick_ipi_reg #(
  parameter int NCPU  = 4,
  parameter int CNT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [63:0]                 wr_data,
  input  logic                        tick,
  input  logic [$clog2(NCPU+1)-1:0]   cpu_count,
  output logic [63:0]                 rd_data,
  output logic [NCPU-1:0]             irq_timer,
  output logic [NCPU-1:0]             irq_ipi
);
  localparam int CW    = $clog2(NCPU+1);
  localparam int TBASE = 4;
  localparam int IBASE = 8;
  localparam int RBASE = 12;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [NCPU-1:0] tstat, istat;
  wire unused_bits = ^{wr_data[63:16], wr_data[3:0]};

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    wire present = CW'(g) < cpu_count;
    wire tclr = wr_en & wr_data[TBASE+g];
    wire iclr = wr_en & wr_data[IBASE+g];
    wire ireq = wr_en & wr_data[RBASE+g];

    logic             t_q, i_q;
    logic [CNT_W-1:0] c_q, c_inc, c_nxt;

    assign c_inc = (ireq && c_q != CMAX) ? c_q + 1'b1 : c_q;
    assign c_nxt = (iclr && c_inc != '0) ? c_inc - 1'b1 : c_inc;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_q <= 1'b0;
        i_q <= 1'b0;
        c_q <= '0;
      end else if (present) begin
        if (t_q)       t_q <= ~tclr;
        else if (tick) t_q <= 1'b1;
        i_q <= (i_q | ireq) & ~iclr;
        c_q <= c_nxt;
      end
    end

    assign tstat[g]     = t_q;
    assign istat[g]     = i_q;
    assign irq_timer[g] = t_q;
    assign irq_ipi[g]   = c_q != '0;
  end

  always_comb begin
    rd_data = '0;
    rd_data[TBASE +: NCPU] = tstat;
    rd_data[IBASE +: NCPU] = istat;
  end
endmodule

module cpu_tick_ipi_reg_chk #(
  parameter int NCPU = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [63:0]               wr_data,
  input logic                      tick,
  input logic [$clog2(NCPU+1)-1:0] cpu_count,
  input logic [63:0]               rd_data,
  input logic [NCPU-1:0]           irq_timer,
  input logic [NCPU-1:0]           irq_ipi
);
  localparam int CW = $clog2(NCPU+1);

  assert_zero_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:12] == '0 && rd_data[3:0] == '0);

  for (genvar g = 0; g < NCPU; g++) begin : g_chk
    assert_tick_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && CW'(g) < cpu_count && !irq_timer[g]) |=> irq_timer[g]);
    assert_tick_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_timer[g] && !(wr_en && wr_data[4+g])) |=> irq_timer[g]);
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[4+g] && irq_timer[g] && CW'(g) < cpu_count) |=> !irq_timer[g]);
    assert_req_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[12+g] && !wr_data[8+g] && CW'(g) < cpu_count) |=> irq_ipi[g] && rd_data[8+g]);
    assert_absent_still_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(g) >= cpu_count) |=> $stable(irq_timer[g]) && $stable(irq_ipi[g]) && $stable(rd_data[8+g]));
  end
endmodule

bind cpu_tick_ipi_reg cpu_tick_ipi_reg_chk #(.NCPU(NCPU)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
  .cpu_count(cpu_count), .rd_data(rd_data), .irq_timer(irq_timer), .irq_ipi(irq_ipi)
);

// File: tb/cpu_tick_ipi_reg_test.sv
module cpu_tick_ipi_reg_test;
  localparam int PERIOD = 10;
  localparam int NCPU   = 4;
  localparam int CMAXI  = 15;

  logic        clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [63:0] wr_data = '0;
  logic [2:0]  cpu_count = 3'd4;
  logic [63:0] rd_data;
  logic [NCPU-1:0] irq_timer, irq_ipi;

  int errors = 0, checks = 0;
  bit done = 0;
  int tst[NCPU], ist[NCPU], cnt[NCPU];

  always #(PERIOD/2) clk = ~clk;

  cpu_tick_ipi_reg #(.NCPU(NCPU), .CNT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tick(tick),
    .cpu_count(cpu_count), .rd_data(rd_data), .irq_timer(irq_timer), .irq_ipi(irq_ipi));

  task automatic compare(input string tag);
    logic [63:0] erd = '0;
    logic [NCPU-1:0] et = '0, ei = '0;
    for (int i = 0; i < NCPU; i++) begin
      erd[4+i] = tst[i] != 0;
      erd[8+i] = ist[i] != 0;
      et[i] = tst[i] != 0;
      ei[i] = cnt[i] > 0;
    end
    checks++;
    if (rd_data !== erd || irq_timer !== et || irq_ipi !== ei) begin
      errors++;
      $display("FAIL %s: rd=%h tmr=%b ipi=%b expected rd=%h tmr=%b ipi=%b",
               tag, rd_data, irq_timer, irq_ipi, erd, et, ei);
    end
  endtask

  task automatic model_update(input logic w, input logic [63:0] d, input logic t, input int n);
    for (int i = 0; i < NCPU; i++) begin
      if (i < n) begin
        if (tst[i] != 0) begin
          if (w && d[4+i]) tst[i] = 0;
        end else if (t) tst[i] = 1;
        if (w && d[12+i]) begin
          ist[i] = 1;
          if (cnt[i] < CMAXI) cnt[i]++;
        end
        if (w && d[8+i]) begin
          ist[i] = 0;
          if (cnt[i] > 0) cnt[i]--;
        end
      end
    end
  endtask

  task automatic step(input logic w, input logic [63:0] d, input logic t, input string tag);
    wr_en = w; wr_data = d; tick = t;
    @(posedge clk);
    model_update(w, d, t, int'(cpu_count));
    @(negedge clk);
    wr_en = 0; wr_data = '0; tick = 0;
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < NCPU; i++) begin tst[i] = 0; ist[i] = 0; cnt[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    step(0, 0, 0, "R1");
    step(0, 0, 1, "R2");
    step(0, 0, 1, "R3");
    step(1, 64'h30, 0, "R4");
    step(1, 64'h20, 0, "R4");
    step(1, 64'h10, 1, "R4");
    step(1, 64'hF0, 0, "R4");
    step(1, 64'h4000, 0, "R5");
    step(1, 64'h4000, 0, "R5");
    step(1, 64'h0400, 0, "R6");
    step(1, 64'h0400, 0, "R6");
    step(1, 64'h0400, 0, "R7");
    for (int k = 0; k < 17; k++) step(1, 64'h8000, 0, "R7");
    for (int k = 0; k < 15; k++) step(1, 64'h0800, 0, "R7");
    step(1, 64'h0800, 0, "R7");
    step(1, 64'h2200, 0, "R8");
    step(1, 64'h2000, 0, "R8");
    step(1, 64'h2200, 0, "R8");
    step(1, 64'h0200, 0, "R8");
    cpu_count = 3'd2;
    step(0, 0, 1, "R9");
    step(1, 64'hF000, 0, "R9");
    cpu_count = 3'd1;
    step(1, 64'hFF30, 1, "R9");
    cpu_count = 3'd4;
    step(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10");
    step(1, 64'hFFFF_FFFF_FFFF_000F, 0, "R10");
    step(1, 64'hABCD_0000_0000_0000, 1, "R10");
    rst_n = 0;
    @(posedge clk);
    for (int i = 0; i < NCPU; i++) begin tst[i] = 0; ist[i] = 0; cnt[i] = 0; end
    @(negedge clk);
    compare("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: R1 run incomplete, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule